// File: doc/BRIEF.md
# Dual-Channel Stream Operand Joiner

This block sits in front of a compute unit that needs two operands: a Cartesian value and a phase value. Each operand arrives on its own valid/ready stream with a last flag and a user sideband. The block combines them into one operation word and presents it on a single output stream. The arithmetic that consumes the word is not part of the block.

A parameter selects between two joining modes. In blocking mode, an operation is formed only once both channels hold data, and the output honours downstream backpressure. In non-blocking mode, data on either channel forms an operation at once. A channel that has not delivered new data supplies the last value it received. In this mode the output is never stalled.

A second parameter picks how the two last flags merge onto the output. Each input channel has a one-entry buffer. Its ready therefore depends only on its own buffer state and the clock enable, and never on the output ready.

Top module: `sjoin_top`

## Requirements
- R1: In blocking mode (BLOCKING=1), no output is produced while only one channel has delivered data. The operation forms once the other channel delivers, and it pairs the two items.
- R2: In non-blocking mode (BLOCKING=0), data accepted on either channel alone produces an output. Data accepted on both channels at the same clock edge produces exactly one output.
- R3: In non-blocking mode, a channel that did not deliver in an operation contributes its most recently accepted data and user bits. Before its first transfer after reset, those values are zero.
- R4: The output last follows LAST_POLICY. The encodings are: 0 gives constant zero; 1 gives the Cartesian last; 2 gives the phase last; 3 gives the OR of the delivering channels' lasts; 4 gives the AND of the delivering channels' lasts. A channel that did not deliver in that operation counts as absent: it adds 0 to the OR and is left out of the AND.
- R5: The output user is the concatenation {phase user, Cartesian user}, with the phase user in the upper PUSER_W bits.
- R6: A channel's ready is high exactly when its buffer is empty and en_i is high. After the channel accepts an item, its ready stays low until that item has been used by an operation.
- R7: In blocking mode, an output held with dout_ready_i low keeps dout_valid_o high and keeps every output field unchanged.
- R8: In non-blocking mode, dout_ready_i has no effect. Each result is presented for one enabled cycle.
- R9: While en_i is low, no transfer happens on any channel, the input readies are low, and the output stays unchanged.
- R10: rst_ni is asynchronous and active low. It clears all buffers, held values and the output valid, and it acts even while en_i is low.
- R11: In blocking mode, results leave in the order the operand pairs arrived, with the n-th item of each channel in the n-th result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; when low, all state is held |
| cart_valid_i | input | 1 | Cartesian channel valid |
| cart_ready_o | output | 1 | Cartesian channel ready |
| cart_data_i | input | CART_W | Cartesian operand |
| cart_last_i | input | 1 | Cartesian last flag |
| cart_user_i | input | CUSER_W | Cartesian user sideband |
| phase_valid_i | input | 1 | Phase channel valid |
| phase_ready_o | output | 1 | Phase channel ready |
| phase_data_i | input | PHASE_W | Phase operand |
| phase_last_i | input | 1 | Phase last flag |
| phase_user_i | input | PUSER_W | Phase user sideband |
| dout_valid_o | output | 1 | Operation word valid |
| dout_ready_i | input | 1 | Downstream ready; used only in blocking mode |
| dout_cart_o | output | CART_W | Cartesian operand of the operation |
| dout_phase_o | output | PHASE_W | Phase operand of the operation |
| dout_user_o | output | CUSER_W+PUSER_W | Merged user sideband |
| dout_last_o | output | 1 | Merged last flag |

## Verification
The hardest state to reach from the ports is a non-blocking operation in which only one channel delivers. The result then mixes fresh data with a held value from an earlier transfer, or with the zero left by reset. The bench gets there on a second instance built in non-blocking mode, with its output ready tied low. It first sends a phase item alone, which exposes the zero Cartesian value. Then it sends a Cartesian item alone, which exposes the held phase value. Finally it sends both in the same cycle, which must merge into one result. A bank of blocking instances that share one stimulus covers the other four last policies on identical traffic. Backpressure, clock-enable freeze and a reset that lands while the enable is low are also driven with a result waiting at the output.

// File: rtl/sjoin_pkg.sv
package sjoin_pkg;
  typedef enum logic [2:0] {
    LAST_ZERO  = 3'd0,
    LAST_CART  = 3'd1,
    LAST_PHASE = 3'd2,
    LAST_OR    = 3'd3,
    LAST_AND   = 3'd4
  } last_pol_e;
endpackage

// File: rtl/sjoin_chan_buf.sv
// One-entry operand buffer; payload persists after pop as the held value.
module sjoin_chan_buf #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         accept;

  assign ready_o = !full_q && en_i;
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (en_i) begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= data_i;
      end else if (pop_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  a_r6_accept_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> full_q && !ready_o);
endmodule

// File: rtl/sjoin_last_merge.sv
module sjoin_last_merge import sjoin_pkg::*; #(
  parameter last_pol_e POLICY = LAST_OR
) (
  input  logic cart_vld_i,
  input  logic cart_last_i,
  input  logic ph_vld_i,
  input  logic ph_last_i,
  output logic last_o
);
  logic c_l, p_l;
  assign c_l = cart_vld_i && cart_last_i;
  assign p_l = ph_vld_i && ph_last_i;

  always_comb begin
    case (POLICY)
      LAST_CART:  last_o = c_l;
      LAST_PHASE: last_o = p_l;
      LAST_OR:    last_o = c_l || p_l;
      LAST_AND:   last_o = (cart_vld_i || ph_vld_i)
                        && (!cart_vld_i || cart_last_i)
                        && (!ph_vld_i || ph_last_i);
      default:    last_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sjoin_out_reg.sv
module sjoin_out_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         free_o,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign free_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (en_i) begin
      if (load_i) begin
        valid_q <= 1'b1;
        data_q  <= data_i;
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  a_r7_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ready_i && en_i |=> valid_q && $stable(data_q));
  a_r9_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(valid_q) && $stable(data_q));
endmodule

// File: rtl/sjoin_top.sv
module sjoin_top import sjoin_pkg::*; #(
  parameter int        CART_W      = 16,
  parameter int        PHASE_W     = 16,
  parameter int        CUSER_W     = 4,
  parameter int        PUSER_W     = 4,
  parameter bit        BLOCKING    = 1'b1,
  parameter last_pol_e LAST_POLICY = LAST_OR
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       cart_valid_i,
  output logic                       cart_ready_o,
  input  logic [CART_W-1:0]          cart_data_i,
  input  logic                       cart_last_i,
  input  logic [CUSER_W-1:0]         cart_user_i,
  input  logic                       phase_valid_i,
  output logic                       phase_ready_o,
  input  logic [PHASE_W-1:0]         phase_data_i,
  input  logic                       phase_last_i,
  input  logic [PUSER_W-1:0]         phase_user_i,
  output logic                       dout_valid_o,
  input  logic                       dout_ready_i,
  output logic [CART_W-1:0]          dout_cart_o,
  output logic [PHASE_W-1:0]         dout_phase_o,
  output logic [CUSER_W+PUSER_W-1:0] dout_user_o,
  output logic                       dout_last_o
);
  localparam int CB_W  = CART_W + CUSER_W + 1;
  localparam int PB_W  = PHASE_W + PUSER_W + 1;
  localparam int OUT_W = CART_W + PHASE_W + CUSER_W + PUSER_W + 1;

  logic            c_full, p_full, fire, out_free, ready_eff, last_m;
  logic [CB_W-1:0] c_buf;
  logic [PB_W-1:0] p_buf;
  logic [OUT_W-1:0] out_d, out_q;

  // Non-blocking output never stalls.
  assign ready_eff = BLOCKING ? dout_ready_i : 1'b1;

  sjoin_chan_buf #(.W(CB_W)) u_cart_buf (
    .clk_i, .rst_ni, .en_i,
    .valid_i(cart_valid_i), .ready_o(cart_ready_o),
    .data_i({cart_last_i, cart_user_i, cart_data_i}),
    .pop_i(fire && c_full), .full_o(c_full), .data_o(c_buf)
  );

  sjoin_chan_buf #(.W(PB_W)) u_phase_buf (
    .clk_i, .rst_ni, .en_i,
    .valid_i(phase_valid_i), .ready_o(phase_ready_o),
    .data_i({phase_last_i, phase_user_i, phase_data_i}),
    .pop_i(fire && p_full), .full_o(p_full), .data_o(p_buf)
  );

  generate
    if (BLOCKING) begin : g_blk
      assign fire = c_full && p_full && out_free;
    end else begin : g_nblk
      assign fire = (c_full || p_full) && out_free;
    end
  endgenerate

  sjoin_last_merge #(.POLICY(LAST_POLICY)) u_last (
    .cart_vld_i(c_full), .cart_last_i(c_buf[CB_W-1]),
    .ph_vld_i(p_full),   .ph_last_i(p_buf[PB_W-1]),
    .last_o(last_m)
  );

  assign out_d = {last_m, p_buf[PB_W-2 -: PUSER_W], c_buf[CB_W-2 -: CUSER_W],
                  p_buf[PHASE_W-1:0], c_buf[CART_W-1:0]};

  sjoin_out_reg #(.W(OUT_W)) u_out (
    .clk_i, .rst_ni, .en_i,
    .load_i(fire), .data_i(out_d), .ready_i(ready_eff),
    .free_o(out_free), .valid_o(dout_valid_o), .data_o(out_q)
  );

  assign dout_cart_o  = out_q[CART_W-1:0];
  assign dout_phase_o = out_q[CART_W +: PHASE_W];
  assign dout_user_o  = out_q[CART_W+PHASE_W +: CUSER_W+PUSER_W];
  assign dout_last_o  = out_q[OUT_W-1];

  generate
    if (BLOCKING) begin : g_chk_blk
      a_r1_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dout_valid_o) |-> $past(c_full && p_full));
    end else begin : g_chk_nblk
      a_r2_single_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && (c_full || p_full) |=> dout_valid_o);
    end
  endgenerate
endmodule

// File: tb/sjoin_top_tb.sv
module sjoin_top_tb;
  import sjoin_pkg::*;
  localparam int CW = 16, PW = 12, CU = 3, PU = 2, UW = CU + PU;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  always #10 clk = ~clk;

  // blocking group inputs/outputs
  logic c_valid = 0, c_last = 0, p_valid = 0, p_last = 0, d_ready = 1;
  logic [CW-1:0] c_data = '0;  logic [CU-1:0] c_user = '0;
  logic [PW-1:0] p_data = '0;  logic [PU-1:0] p_user = '0;
  logic c_ready, p_ready, d_valid, d_last;
  logic [CW-1:0] d_cart; logic [PW-1:0] d_phase; logic [UW-1:0] d_user;
  logic [3:0] pol_last;

  // non-blocking instance
  logic n_cv = 0, n_cl = 0, n_pv = 0, n_pl = 0;
  logic [CW-1:0] n_cd = '0; logic [CU-1:0] n_cu = '0;
  logic [PW-1:0] n_pd = '0; logic [PU-1:0] n_pu = '0;
  logic n_cr, n_pr, n_dv, n_dl;
  logic [CW-1:0] n_dc; logic [PW-1:0] n_dp; logic [UW-1:0] n_du;

  sjoin_top #(.CART_W(CW), .PHASE_W(PW), .CUSER_W(CU), .PUSER_W(PU),
              .BLOCKING(1'b1), .LAST_POLICY(LAST_OR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .cart_valid_i(c_valid), .cart_ready_o(c_ready), .cart_data_i(c_data),
    .cart_last_i(c_last), .cart_user_i(c_user),
    .phase_valid_i(p_valid), .phase_ready_o(p_ready), .phase_data_i(p_data),
    .phase_last_i(p_last), .phase_user_i(p_user),
    .dout_valid_o(d_valid), .dout_ready_i(d_ready), .dout_cart_o(d_cart),
    .dout_phase_o(d_phase), .dout_user_o(d_user), .dout_last_o(d_last));

  for (genvar g = 0; g < 4; g++) begin : g_pol
    logic cr, pr, dv;
    logic [CW-1:0] dc; logic [PW-1:0] dp; logic [UW-1:0] du;
    sjoin_top #(.CART_W(CW), .PHASE_W(PW), .CUSER_W(CU), .PUSER_W(PU),
                .BLOCKING(1'b1), .LAST_POLICY(last_pol_e'((g == 3) ? 4 : g))) u_pol (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en),
      .cart_valid_i(c_valid), .cart_ready_o(cr), .cart_data_i(c_data),
      .cart_last_i(c_last), .cart_user_i(c_user),
      .phase_valid_i(p_valid), .phase_ready_o(pr), .phase_data_i(p_data),
      .phase_last_i(p_last), .phase_user_i(p_user),
      .dout_valid_o(dv), .dout_ready_i(d_ready), .dout_cart_o(dc),
      .dout_phase_o(dp), .dout_user_o(du), .dout_last_o(pol_last[g]));
  end

  sjoin_top #(.CART_W(CW), .PHASE_W(PW), .CUSER_W(CU), .PUSER_W(PU),
              .BLOCKING(1'b0), .LAST_POLICY(LAST_AND)) u_nb (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .cart_valid_i(n_cv), .cart_ready_o(n_cr), .cart_data_i(n_cd),
    .cart_last_i(n_cl), .cart_user_i(n_cu),
    .phase_valid_i(n_pv), .phase_ready_o(n_pr), .phase_data_i(n_pd),
    .phase_last_i(n_pl), .phase_user_i(n_pu),
    .dout_valid_o(n_dv), .dout_ready_i(1'b0), .dout_cart_o(n_dc),
    .dout_phase_o(n_dp), .dout_user_o(n_du), .dout_last_o(n_dl));

  typedef struct {
    logic [CW-1:0] c; logic [PW-1:0] p; logic [UW-1:0] u;
    logic l_or; logic [3:0] l_pol;
  } exp_t;
  exp_t q_blk[$], q_nb[$], eb, en_e;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // scoreboard monitors
  always @(negedge clk) if (rst_n && !done) begin
    if (d_valid && d_ready && en) begin
      if (q_blk.size() == 0) chk(0, "R1 unexpected blocking result", d_cart, 0);
      else begin
        eb = q_blk.pop_front();
        chk(d_cart == eb.c, "R11 cart operand", d_cart, eb.c);
        chk(d_phase == eb.p, "R11 phase operand", d_phase, eb.p);
        chk(d_user == eb.u, "R5 user concat", d_user, eb.u);
        chk(d_last == eb.l_or, "R4 policy OR", d_last, eb.l_or);
        chk(pol_last == eb.l_pol, "R4 policies zero/cart/phase/and", pol_last, eb.l_pol);
      end
    end
    if (n_dv && en) begin
      if (q_nb.size() == 0) chk(0, "R8 extra non-blocking result", n_dc, 0);
      else begin
        en_e = q_nb.pop_front();
        chk(n_dc == en_e.c, "R3 cart operand", n_dc, en_e.c);
        chk(n_dp == en_e.p, "R3 phase operand", n_dp, en_e.p);
        chk(n_du == en_e.u, "R5 nb user concat", n_du, en_e.u);
        chk(n_dl == en_e.l_or, "R4 nb policy AND", n_dl, en_e.l_or);
      end
    end
  end

  task automatic drive_c(input logic [CW-1:0] d, input logic l, input logic [CU-1:0] u);
    step(); c_valid = 1; c_data = d; c_last = l; c_user = u;
    while (!(c_ready && en)) step();
    step(); c_valid = 0;
  endtask

  task automatic drive_p(input logic [PW-1:0] d, input logic l, input logic [PU-1:0] u);
    step(); p_valid = 1; p_data = d; p_last = l; p_user = u;
    while (!(p_ready && en)) step();
    step(); p_valid = 0;
  endtask

  function automatic exp_t mk_blk(logic [CW-1:0] cd, logic cl, logic [CU-1:0] cu,
                                  logic [PW-1:0] pd, logic pl, logic [PU-1:0] pu);
    exp_t e;
    e.c = cd; e.p = pd; e.u = {pu, cu}; e.l_or = cl | pl;
    e.l_pol = {cl & pl, pl, cl, 1'b0};
    return e;
  endfunction

  task automatic send_blk(input logic [CW-1:0] cd, input logic cl, input logic [CU-1:0] cu,
                          input logic [PW-1:0] pd, input logic pl, input logic [PU-1:0] pu);
    q_blk.push_back(mk_blk(cd, cl, cu, pd, pl, pu));
    fork
      drive_c(cd, cl, cu);
      drive_p(pd, pl, pu);
    join
  endtask

  // non-blocking model state
  logic [CW-1:0] h_cd = '0; logic [CU-1:0] h_cu = '0;
  logic [PW-1:0] h_pd = '0; logic [PU-1:0] h_pu = '0;

  task automatic nb_send(input bit dc, input bit dp,
                         input logic [CW-1:0] cd, input logic cl, input logic [CU-1:0] cu,
                         input logic [PW-1:0] pd, input logic pl, input logic [PU-1:0] pu);
    exp_t e;
    if (dc) begin h_cd = cd; h_cu = cu; end
    if (dp) begin h_pd = pd; h_pu = pu; end
    e.c = h_cd; e.p = h_pd; e.u = {h_pu, h_cu};
    e.l_or = (dc || dp) && (!dc || cl) && (!dp || pl);
    e.l_pol = '0;
    q_nb.push_back(e);
    step();
    n_cv = dc; n_pv = dp; n_cd = cd; n_cl = cl; n_cu = cu; n_pd = pd; n_pl = pl; n_pu = pu;
    while (!((!dc || n_cr) && (!dp || n_pr) && en)) step();
    step(); n_cv = 0; n_pv = 0;
    repeat (4) step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired R1 actual=running expected=done");
    finish_run();
  end

  logic [CW-1:0] sv_c; logic [PW-1:0] sv_p; logic [UW-1:0] sv_u;

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(d_valid == 0, "R10 blocking valid in reset", d_valid, 0);
    chk(n_dv == 0, "R10 nb valid in reset", n_dv, 0);
    step(); rst_n = 1;
    @(negedge clk);
    chk(c_ready == 1, "R6 cart ready idle", c_ready, 1);
    chk(p_ready == 1, "R6 phase ready idle", p_ready, 1);

    // R1 R4 R5 R11: blocking pairs with all last combinations
    send_blk(16'h1234, 0, 3'h5, 12'hABC, 0, 2'h2);
    send_blk(16'h8001, 1, 3'h7, 12'h00F, 0, 2'h1);
    send_blk(16'h0FF0, 0, 3'h0, 12'h800, 1, 2'h3);
    send_blk(16'hFFFF, 1, 3'h2, 12'h555, 1, 2'h0);
    repeat (6) step();

    // R1 stall: cart alone must not produce a result
    q_blk.push_back(mk_blk(16'h4242, 1, 3'h1, 12'h321, 0, 2'h3));
    fork drive_c(16'h4242, 1, 3'h1); join_none
    repeat (6) begin
      @(negedge clk);
      chk(d_valid == 0, "R1 stall with one channel", d_valid, 0);
    end
    chk(c_ready == 0, "R6 cart ready low while buffered", c_ready, 0);
    drive_p(12'h321, 0, 2'h3);
    repeat (6) step();

    // R7 backpressure
    d_ready = 0;
    send_blk(16'h7777, 0, 3'h6, 12'h123, 1, 2'h1);
    while (!d_valid) step();
    sv_c = d_cart; sv_p = d_phase; sv_u = d_user;
    repeat (4) begin
      step();
      chk(d_valid == 1, "R7 valid held on stall", d_valid, 1);
      chk({d_cart, d_phase, d_user} == {sv_c, sv_p, sv_u}, "R7 data stable on stall",
          {d_cart, d_phase, d_user}, {sv_c, sv_p, sv_u});
    end
    d_ready = 1;
    repeat (4) step();

    // R9 clock enable freeze with a result waiting
    d_ready = 0;
    send_blk(16'h0101, 1, 3'h3, 12'h0A0, 1, 2'h2);
    while (!d_valid) step();
    step(); en = 0; d_ready = 1;
    repeat (4) begin
      step();
      chk(d_valid == 1, "R9 output held with enable low", d_valid, 1);
      chk(c_ready == 0, "R9 cart ready low with enable low", c_ready, 0);
      chk(p_ready == 0, "R9 phase ready low with enable low", p_ready, 0);
    end
    step(); en = 1;
    repeat (4) step();

    // R2 R3 R8: non-blocking, output ready tied low
    nb_send(0, 1, 16'h0, 0, 3'h0, 12'h9A5, 1, 2'h3);
    nb_send(1, 0, 16'h5A5A, 0, 3'h4, 12'h0, 1, 2'h0);
    nb_send(1, 1, 16'h1357, 1, 3'h2, 12'h246, 1, 2'h1);
    nb_send(1, 0, 16'hC0DE, 1, 3'h7, 12'h0, 0, 2'h0);
    @(negedge clk);
    chk(q_nb.size() == 0, "R2 every nb operation produced", q_nb.size(), 0);
    chk(q_blk.size() == 0, "R11 every blocking pair produced", q_blk.size(), 0);

    // R10 reset while enable low and a result is pending
    d_ready = 0;
    send_blk(16'hBEEF, 0, 3'h1, 12'hFED, 0, 2'h1);
    while (!d_valid) step();
    step(); en = 0; q_blk.delete(); rst_n = 0;
    #1;
    chk(d_valid == 0, "R10 reset overrides enable", d_valid, 0);
    step(); rst_n = 1; en = 1; d_ready = 1;
    @(negedge clk);
    chk(c_ready == 1, "R10 cart buffer cleared", c_ready, 1);
    chk(d_valid == 0, "R10 no result after reset", d_valid, 0);
    finish_run();
  end
endmodule